// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register front end of a general-purpose I/O controller. It has several banks of 32 pins each, and all of them sit behind one word-wide register bus. The bus has a byte address, a write strobe, write data and combinational read data. For every pin the block keeps a direction bit and an output latch. It drives the pin output value and the output enable from those two bits. It samples the pin level through a two-stage synchronizer so that software can read it.

Registers are grouped by function, and the copies for the separate banks sit in neighbouring words. The function selects a 16-byte slot and the bank selects a word inside that slot. Software changes output levels through two write-only strobe registers, one that raises bits and one that lowers them. This lets two agents update different pins of the same bank without a read-modify-write race. The interrupt function slots (polarity, edge and level enables, status, edge) are reserved here. They read as zero and writes to them do nothing.

Top module: `gpio_bank_regfile`

## Requirements
- R1: While reset is high and immediately after it, every direction bit and every output latch is zero: `pin_oe` and `pin_out` are all zero and the direction register of every bank reads 0.
- R2: A register's byte address is function × 0x10 + bank × 4. The function is taken from address bits [7:4] and the bank from bits [3:2], and address bits [1:0] are ignored. The banks are fully independent.
- R3: Function 0 is the direction register. A write stores the whole word, and a read returns it. Bit n = 1 makes pin n of that bank an output (`pin_oe` high), and 0 makes it an input. The new value appears on the first clock edge after the write.
- R4: Function 3 is the set strobe. Each 1 in the written word sets that bank's output latch bit to 1, and each 0 leaves the bit unchanged. The result is visible after one clock edge.
- R5: Function 4 is the clear strobe. Each 1 in the written word sets that bank's output latch bit to 0, and each 0 leaves the bit unchanged. The result is visible after one clock edge.
- R6: Function 2 is the data register. A read returns the bank's pin levels after a two-flop synchronizer. A change on `pin_in` shows up in the readback after exactly two rising clock edges.
- R7: The set and clear registers read as zero. A write to the data register changes neither the latches nor the directions.
- R8: An access to function 1 or to functions 5 to 15, or to a bank number of 3 or more, reads as zero, and a write to it changes no state.
- R9: `pin_out` always shows the output latch, including while the pin is an input. When a pin is later switched to output, it drives the last value that was set or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 96 | Pin levels, bank b at bits [32b+31:32b] |
| pin_out | output | 96 | Output latch values per pin |
| pin_oe | output | 96 | Output enable per pin (1 = drive) |

## Verification
Suppose a bank's direction or output latch holds a wrong bit. It shows on `pin_oe` or `pin_out` on the very edge after the write that caused it, and it shows in the direction readback in that same cycle. A decode slip, such as a wrong bank field or an interrupt slot that is not blocked, shows up as a changed latch in a bank that was never addressed, or as nonzero readback from a reserved word. Both are visible one edge after the stray write. A synchronizer that is one stage too short or too long moves the data readback by one edge, and the bench catches this by checking both sides of the two-edge boundary.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned NUM_BANKS = 3;
    localparam int unsigned PINS      = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned FN_LSB    = 4;
    localparam int unsigned FN_W      = ADDR_W - FN_LSB;
    localparam int unsigned BANK_LSB  = 2;
    localparam int unsigned BANK_W    = FN_LSB - BANK_LSB;
    localparam int unsigned ALL_PINS  = NUM_BANKS * PINS;

    localparam logic [FN_W-1:0] FN_DIR  = 4'd0;
    localparam logic [FN_W-1:0] FN_DATA = 4'd2;
    localparam logic [FN_W-1:0] FN_SET  = 4'd3;
    localparam logic [FN_W-1:0] FN_CLR  = 4'd4;

    typedef struct packed {
        logic              hit;   // implemented function and existing bank
        logic [FN_W-1:0]   fn;
        logic [BANK_W-1:0] bank;
    } gpio_dec_t;

    typedef struct packed {
        logic dir_we;
        logic set_we;
        logic clr_we;
    } bank_wr_t;

    function automatic logic fn_is_live(input logic [FN_W-1:0] fn);
        return (fn == FN_DIR) || (fn == FN_DATA) || (fn == FN_SET) || (fn == FN_CLR);
    endfunction

    function automatic gpio_dec_t decode_addr(input logic [ADDR_W-1:0] addr);
        gpio_dec_t d;
        d.fn   = addr[ADDR_W-1:FN_LSB];
        d.bank = addr[FN_LSB-1:BANK_LSB];
        d.hit  = fn_is_live(d.fn) && (int'(d.bank) < NUM_BANKS);
        return d;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output gpio_dec_t         dec,
    output bank_wr_t          bank_wr [NUM_BANKS]
);
    always_comb dec = decode_addr(addr);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
        logic sel;
        assign sel = wr && dec.hit && (int'(dec.bank) == b);
        assign bank_wr[b].dir_we = sel && (dec.fn == FN_DIR);
        assign bank_wr[b].set_we = sel && (dec.fn == FN_SET);
        assign bank_wr[b].clr_we = sel && (dec.fn == FN_CLR);
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bank_wr_t        wr,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] in_sync
);
    logic [PINS-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (wr.dir_we) dir_q <= wdata;
            if (wr.set_we)      out_q <= out_q | wdata;
            else if (wr.clr_we) out_q <= out_q & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            in_sync <= '0;
        end else begin
            meta_q  <= pad_in;
            in_sync <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [PINS-1:0]     bus_wdata,
    output logic [PINS-1:0]     bus_rdata,
    input  logic [ALL_PINS-1:0] pin_in,
    output logic [ALL_PINS-1:0] pin_out,
    output logic [ALL_PINS-1:0] pin_oe
);
    gpio_dec_t       dec;
    bank_wr_t        bank_wr [NUM_BANKS];
    logic [PINS-1:0] dir_v  [NUM_BANKS];
    logic [PINS-1:0] out_v  [NUM_BANKS];
    logic [PINS-1:0] sync_v [NUM_BANKS];

    gpio_addr_decode u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .dec     (dec),
        .bank_wr (bank_wr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank_ctrl u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr      (bank_wr[b]),
            .wdata   (bus_wdata),
            .pad_in  (pin_in[b*PINS +: PINS]),
            .dir_q   (dir_v[b]),
            .out_q   (out_v[b]),
            .in_sync (sync_v[b])
        );
        assign pin_oe [b*PINS +: PINS] = dir_v[b];
        assign pin_out[b*PINS +: PINS] = out_v[b];
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && int'(dec.bank) == b) begin
                if (dec.fn == FN_DIR)  bus_rdata = dir_v[b];
                if (dec.fn == FN_DATA) bus_rdata = sync_v[b];
            end
        end
    end
endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk
    import gpio_bank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [PINS-1:0]     bus_wdata,
    input logic [PINS-1:0]     bus_rdata,
    input logic [ALL_PINS-1:0] pin_in,
    input logic [ALL_PINS-1:0] pin_out,
    input logic [ALL_PINS-1:0] pin_oe
);
    logic [FN_W-1:0]   a_fn;
    logic [BANK_W-1:0] a_bank;
    logic              a_dead;
    logic              rst_seen_q;

    assign a_fn   = bus_addr[ADDR_W-1:FN_LSB];
    assign a_bank = bus_addr[FN_LSB-1:BANK_LSB];
    assign a_dead = !fn_is_live(a_fn) || (int'(a_bank) >= NUM_BANKS);

    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: state is cleared on the edge after reset is sampled
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (pin_oe == '0 && pin_out == '0);
        end
    end

    p_dead_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        a_dead |-> bus_rdata == '0);

    p_dead_write_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && a_dead) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_strobe_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (a_fn == FN_SET || a_fn == FN_CLR) |-> bus_rdata == '0);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a_fn == FN_DIR && int'(a_bank) == b)
            |=> pin_oe[b*PINS +: PINS] == $past(bus_wdata));

        p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a_fn == FN_SET && int'(a_bank) == b)
            |=> pin_out[b*PINS +: PINS] == ($past(pin_out[b*PINS +: PINS]) | $past(bus_wdata)));

        p_clr_bits_r5: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a_fn == FN_CLR && int'(a_bank) == b)
            |=> pin_out[b*PINS +: PINS] == ($past(pin_out[b*PINS +: PINS]) & ~$past(bus_wdata)));

        p_data_write_inert_r7: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && a_fn == FN_DATA && int'(a_bank) == b)
            |=> ($stable(pin_out[b*PINS +: PINS]) && $stable(pin_oe[b*PINS +: PINS])));
    end
endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk chk_i (.*);

// File: tb/gpio_bank_regfile_tb_top.sv
module gpio_bank_regfile_tb_top;
    import gpio_bank_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic                bus_wr = 1'b0;
    logic [PINS-1:0]     bus_wdata = '0;
    logic [PINS-1:0]     bus_rdata;
    logic [ALL_PINS-1:0] pin_in = {32'hCAFE0000, 32'h12345678, 32'hA5A5F00F};
    logic [ALL_PINS-1:0] pin_out;
    logic [ALL_PINS-1:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_regfile dut_i (.*);

    typedef struct packed {
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'hFFFF0000, 8'h00, 32'hFFFF0000}, // R3 dir bank0
        '{1'b1, 8'h08, 32'h0000FFFF, 8'h08, 32'h0000FFFF}, // R2 dir bank2
        '{1'b0, 8'h00, 32'h0,        8'h04, 32'h00000000}, // R2 bank1 untouched
        '{1'b1, 8'h30, 32'h000000F0, 8'h30, 32'h00000000}, // R7 set reads 0
        '{1'b1, 8'h34, 32'h80000001, 8'h24, 32'h12345678}, // R6 data bank1
        '{1'b1, 8'h40, 32'h00000030, 8'h40, 32'h00000000}, // R7 clear reads 0
        '{1'b1, 8'h20, 32'hFFFFFFFF, 8'h20, 32'hA5A5F00F}, // R7 data write ignored
        '{1'b1, 8'h0C, 32'h00001234, 8'h0C, 32'h00000000}, // R8 bank3
        '{1'b1, 8'h10, 32'hFFFFFFFF, 8'h10, 32'h00000000}, // R8 polarity slot
        '{1'b1, 8'h50, 32'h000000FF, 8'h50, 32'h00000000}, // R8 edge enable slot
        '{1'b0, 8'h00, 32'h0,        8'hA8, 32'h00000000}, // R8 edge slot bank2
        '{1'b0, 8'h00, 32'h0,        8'h01, 32'hFFFF0000}  // R2 low bits ignored
    };

    task automatic check(input string req, input logic [ALL_PINS-1:0] act,
                         input logic [ALL_PINS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = a;
        #1 check(req, {64'h0, bus_rdata}, {64'h0, exp});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1 oe in reset", pin_oe, '0);
        check("R1 out in reset", pin_out, '0);
        rst = 1'b0;
        rd_check("R1 dir reads 0", 8'h00, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr = VEC[i].wr; bus_addr = VEC[i].waddr; bus_wdata = VEC[i].wdata;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = VEC[i].raddr;
            #1 check($sformatf("vector %0d R2/R3/R6/R7/R8", i),
                     {64'h0, bus_rdata}, {64'h0, VEC[i].exp});
        end

        // R4, R5: latch contents after set F0, clear 30 on bank0, set on bank1
        check("R4 R5 latches", pin_out, {32'h0, 32'h80000001, 32'h000000C0});
        // R3, R8: enables unaffected by reserved writes
        check("R3 R8 enables", pin_oe, {32'h0000FFFF, 32'h0, 32'hFFFF0000});

        // R9: bank1 latch held while input, driven when made output
        wr(8'h04, 32'hFFFFFFFF);
        check("R9 latch kept", pin_out[63:32], {64'h0, 32'h80000001});
        check("R9 now driven", pin_oe[63:32], {64'h0, 32'hFFFFFFFF});

        // R5: clear with zero bits leaves latch alone
        wr(8'h44, 32'h00000001);
        check("R5 partial clear", pin_out[63:32], {64'h0, 32'h80000000});

        // R6: two-edge synchronizer latency on bank0
        @(negedge clk);
        bus_addr = 8'h20;
        pin_in[31:0] = 32'h11111111;
        @(negedge clk);
        #1 check("R6 after one edge", {64'h0, bus_rdata}, {64'h0, 32'hA5A5F00F});
        @(negedge clk);
        #1 check("R6 after two edges", {64'h0, bus_rdata}, {64'h0, 32'h11111111});

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", pin_oe, '0);
        check("R1 out after reset", pin_out, '0);
        rst = 1'b0;
        rd_check("R1 dir after reset", 8'h08, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule